// File: doc/BRIEF.md
# PCI Function Configuration State Controller

This block keeps the life-cycle state of a set of attachable PCI functions (32 by default) and serves configure and deconfigure service requests aimed at them. Every function slot holds an occupancy bit, a function identifier and a two-bit state: reserved, standby, disabled or enabled. Each slot also carries three flags: interrupt summary registered, address translation registered, and release pending. A slot setup port loads all of these fields when a function is plugged, enabled or marked for release.

A request carries an operation, a function identifier and a request block length. The block checks the length and searches the slots in index order for the identifier. It then applies the state transition and returns a response code as a one-cycle pulse. A deconfigure that takes a function out of use also pulses clean-up strobes for the interrupt and translation registrations. State changes push availability events into a small ordered event queue. An external source can push error events into the same queue. A consumer pops the events one at a time. When it pops an event for a slot that is being released, the block also raises an unplug request.

Top module: `cfg_state_ctrl`

## Requirements
- R1: After reset every slot is unoccupied, no event is pending, the lost flag is 0 and resp_valid is 0. A request for any identifier then returns code 4.
- R2: A request whose length is below 16 returns code 5 (too short). It changes no state, pushes no event and pulses no strobe, whether or not the identifier exists.
- R3: A request of length 16 or more whose identifier matches no occupied slot returns code 4 (unknown identifier).
- R4: Configure (req_op=0) on a standby slot moves it to disabled and returns code 1 (done). On a reserved slot it returns code 3 (reserved). On a disabled or enabled slot it returns code 2 (nothing to do). State encoding: 0 reserved, 1 standby, 2 disabled, 3 enabled.
- R5: Deconfigure (req_op=1) returns code 3 on a reserved slot and code 2 on a standby slot. On a disabled or enabled slot it moves the slot to standby and returns code 1.
- R6: A deconfigure that returns code 1 pulses dereg_irq if the slot's summary flag was set and dereg_xlat if its translation flag was set. Both pulses come in the same cycle as resp_valid, with dereg_slot giving the slot index. Both flags are then cleared.
- R7: The lowest-index occupied slot whose identifier matches is used. resp_valid is high for exactly one cycle, two clock edges after the edge that accepts the request.
- R8: Every code-1 response pushes an availability event (kind 2) carrying the identifier. err_push pushes an error event (kind 1). Events leave in arrival order through ev_kind and ev_fid. ev_pending shows that the queue is not empty, and ev_pop removes the head.
- R9: A successful deconfigure of a slot whose release flag is set marks its event. Popping a marked event raises unplug_req in the same cycle. Unmarked events never raise it.
- R10: A push into a full queue with no pop in the same cycle is dropped, and ev_lost is set. An error push in the same cycle as an availability push is dropped, and ev_lost is set. ev_lost stays set until reset.
- R11: A request presented while an earlier one is still in flight is ignored and produces no response.
- R12: A slot setup write changes the slot's occupancy, identifier, state and flags at the next edge. Later requests see the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_we | input | 1 | Slot setup write strobe |
| slot_idx | input | IDX_W | Slot written |
| slot_occ | input | 1 | Slot occupied |
| slot_fid | input | FID_W | Function identifier |
| slot_state | input | 2 | Life-cycle state |
| slot_sum | input | 1 | Interrupt summary registered |
| slot_xlat | input | 1 | Address translation registered |
| slot_rel | input | 1 | Release pending |
| req_valid | input | 1 | Request strobe |
| req_op | input | 1 | 0 configure, 1 deconfigure |
| req_fid | input | FID_W | Target identifier |
| req_len | input | LEN_W | Request block length |
| resp_valid | output | 1 | Response pulse |
| resp_code | output | 4 | Response code |
| dereg_irq | output | 1 | Interrupt deregistration strobe |
| dereg_xlat | output | 1 | Translation deregistration strobe |
| dereg_slot | output | IDX_W | Slot the strobes refer to |
| err_push | input | 1 | Push an error event |
| err_fid | input | FID_W | Identifier for the error event |
| ev_pop | input | 1 | Remove the head event |
| ev_pending | output | 1 | Queue not empty |
| ev_kind | output | 2 | Head event kind |
| ev_fid | output | FID_W | Head event identifier |
| unplug_req | output | 1 | Unplug request on pop of a marked event |
| ev_lost | output | 1 | Sticky dropped-event flag |

## Verification
The bench keeps the full 32 slots, so the lowest-index rule and the top slot index 31 are both exercised. It narrows the identifier to 8 bits and the event queue to 4 entries. The shallow queue lets a few error pushes fill it and reach the drop path. A second reset between scenarios gives a clean lost flag for the collision between an availability push and an error push.

// File: rtl/cfg_state_pkg.sv
// Shared encodings for the function configuration state controller.
// Assumes: two-bit slot state and four-bit response code on the ports.
package cfg_state_pkg;
    typedef enum logic [1:0] {
        SL_RESERVED = 2'd0,
        SL_STANDBY  = 2'd1,
        SL_DISABLED = 2'd2,
        SL_ENABLED  = 2'd3
    } slot_state_e;

    localparam logic [3:0] RC_DONE    = 4'd1;
    localparam logic [3:0] RC_NOTHING = 4'd2;
    localparam logic [3:0] RC_RSVD    = 4'd3;
    localparam logic [3:0] RC_UNKNOWN = 4'd4;
    localparam logic [3:0] RC_SHORT   = 4'd5;

    localparam logic [1:0] EV_ERROR = 2'd1;
    localparam logic [1:0] EV_AVAIL = 2'd2;

    localparam int MIN_LEN = 16;
endpackage

// File: rtl/cfg_fid_match.sv
// Identifier search: compares the key against every occupied slot at once
// and reports the lowest matching index. Pure combinational logic.
// Assumes: key and slot identifiers have equal width.
module cfg_fid_match #(
    parameter int NSLOTS = 32,
    parameter int FID_W  = 32,
    parameter int IDX_W  = $clog2(NSLOTS)
) (
    input  logic [NSLOTS-1:0]            occ,
    input  logic [NSLOTS-1:0][FID_W-1:0] fids,
    input  logic [FID_W-1:0]             key,
    output logic                         hit,
    output logic [IDX_W-1:0]             idx
);
    logic [NSLOTS-1:0] eq;

    for (genvar g = 0; g < NSLOTS; g++) begin : g_cmp
        assign eq[g] = occ[g] && (fids[g] == key);
    end

    // Lowest index wins: scan downward so the last write is the smallest.
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = NSLOTS - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/cfg_slot_table.sv
// Slot storage: occupancy, identifier, state and three flags per slot.
// Setup writes take priority over request-driven updates to the same slot.
// Assumes: at most one setup write and one update per cycle.
module cfg_slot_table
    import cfg_state_pkg::*;
#(
    parameter int NSLOTS = 32,
    parameter int FID_W  = 32,
    parameter int IDX_W  = $clog2(NSLOTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         set_we,
    input  logic [IDX_W-1:0]             set_idx,
    input  logic                         set_occ,
    input  logic [FID_W-1:0]             set_fid,
    input  logic [1:0]                   set_state,
    input  logic                         set_sum,
    input  logic                         set_xlat,
    input  logic                         set_rel,
    input  logic                         upd_we,
    input  logic [IDX_W-1:0]             upd_idx,
    input  logic [1:0]                   upd_state,
    input  logic                         upd_clr,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [NSLOTS-1:0]            occ_vec,
    output logic [NSLOTS-1:0][FID_W-1:0] fid_vec,
    output logic [1:0]                   rd_state,
    output logic                         rd_sum,
    output logic                         rd_xlat,
    output logic                         rd_rel
);
    logic [NSLOTS-1:0][1:0] st_q;
    logic [NSLOTS-1:0]      sum_q, xlat_q, rel_q;

    // Per-slot storage: reset clears, setup overrides, update moves state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_vec <= '0;
            fid_vec <= '0;
            st_q    <= '0;
            sum_q   <= '0;
            xlat_q  <= '0;
            rel_q   <= '0;
        end else begin
            if (upd_we && !(set_we && set_idx == upd_idx)) begin
                st_q[upd_idx] <= upd_state;
                if (upd_clr) begin
                    sum_q[upd_idx]  <= 1'b0;
                    xlat_q[upd_idx] <= 1'b0;
                end
            end
            if (set_we) begin
                occ_vec[set_idx] <= set_occ;
                fid_vec[set_idx] <= set_fid;
                st_q[set_idx]    <= set_state;
                sum_q[set_idx]   <= set_sum;
                xlat_q[set_idx]  <= set_xlat;
                rel_q[set_idx]   <= set_rel;
            end
        end
    end

    // Read port for the slot selected by the search result.
    always_comb begin
        rd_state = st_q[rd_idx];
        rd_sum   = sum_q[rd_idx];
        rd_xlat  = xlat_q[rd_idx];
        rd_rel   = rel_q[rd_idx];
    end
endmodule

// File: rtl/cfg_event_fifo.sv
// Ordered event queue with two push sources and a single pop.
// An availability push wins over an error push in the same cycle. A loser,
// or a push into a full queue with no pop, is dropped and sets a sticky flag.
// Assumes: DEPTH is a power of two.
module cfg_event_fifo
    import cfg_state_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int FID_W = 32,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             av_push,
    input  logic [FID_W-1:0] av_fid,
    input  logic             av_rel,
    input  logic             er_push,
    input  logic [FID_W-1:0] er_fid,
    input  logic             pop,
    output logic             pending,
    output logic [1:0]       head_kind,
    output logic [FID_W-1:0] head_fid,
    output logic             head_rel,
    output logic [PTR_W:0]   count,
    output logic             push_acc,
    output logic             lost
);
    logic [DEPTH-1:0][1:0]       kind_m;
    logic [DEPTH-1:0][FID_W-1:0] fid_m;
    logic [DEPTH-1:0]            rel_m;
    logic [PTR_W-1:0]            wr_p, rd_p;
    logic                        any_push, pop_ok, full;
    logic [1:0]                  w_kind;
    logic [FID_W-1:0]            w_fid;
    logic                        w_rel;

    // Source selection and accept/drop decision.
    always_comb begin
        full     = (count == (PTR_W+1)'(DEPTH));
        pop_ok   = pop && (count != '0);
        any_push = av_push || er_push;
        push_acc = any_push && (!full || pop_ok);
        w_kind   = av_push ? EV_AVAIL : EV_ERROR;
        w_fid    = av_push ? av_fid : er_fid;
        w_rel    = av_push && av_rel;
    end

    // Storage, pointers, occupancy count and sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p  <= '0;
            rd_p  <= '0;
            count <= '0;
            lost  <= 1'b0;
            kind_m <= '0;
            fid_m  <= '0;
            rel_m  <= '0;
        end else begin
            if (push_acc) begin
                kind_m[wr_p] <= w_kind;
                fid_m[wr_p]  <= w_fid;
                rel_m[wr_p]  <= w_rel;
                wr_p         <= wr_p + 1'b1;
            end
            if (pop_ok) rd_p <= rd_p + 1'b1;
            count <= count + (PTR_W+1)'(push_acc) - (PTR_W+1)'(pop_ok);
            if ((any_push && !push_acc) || (av_push && er_push)) lost <= 1'b1;
        end
    end

    // Head of queue presented to the consumer.
    always_comb begin
        pending   = (count != '0);
        head_kind = kind_m[rd_p];
        head_fid  = fid_m[rd_p];
        head_rel  = rel_m[rd_p];
    end
endmodule

// File: rtl/cfg_state_ctrl.sv
// Top: accepts configure/deconfigure requests, searches the slots, applies
// the transition and answers two edges after acceptance. It drives clean-up
// strobes and queues availability events.
// Assumes: requests are presented only when the previous one has answered;
// others are ignored.
module cfg_state_ctrl
    import cfg_state_pkg::*;
#(
    parameter int NSLOTS     = 32,
    parameter int FID_W      = 32,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 8,
    localparam int IDX_W     = $clog2(NSLOTS),
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_we,
    input  logic [IDX_W-1:0] slot_idx,
    input  logic             slot_occ,
    input  logic [FID_W-1:0] slot_fid,
    input  logic [1:0]       slot_state,
    input  logic             slot_sum,
    input  logic             slot_xlat,
    input  logic             slot_rel,
    input  logic             req_valid,
    input  logic             req_op,
    input  logic [FID_W-1:0] req_fid,
    input  logic [LEN_W-1:0] req_len,
    output logic             resp_valid,
    output logic [3:0]       resp_code,
    output logic             dereg_irq,
    output logic             dereg_xlat,
    output logic [IDX_W-1:0] dereg_slot,
    input  logic             err_push,
    input  logic [FID_W-1:0] err_fid,
    input  logic             ev_pop,
    output logic             ev_pending,
    output logic [1:0]       ev_kind,
    output logic [FID_W-1:0] ev_fid,
    output logic             unplug_req,
    output logic             ev_lost
);
    logic             s1_v, s1_op, s1_short;
    logic [FID_W-1:0] s1_fid;
    logic             s2_v, s2_op, s2_short, s2_hit;
    logic [FID_W-1:0] s2_fid;
    logic [IDX_W-1:0] s2_idx;
    logic             m_hit;
    logic [IDX_W-1:0] m_idx;

    logic [NSLOTS-1:0]            occ_vec;
    logic [NSLOTS-1:0][FID_W-1:0] fid_vec;
    logic [1:0]                   cur_st;
    logic                         cur_sum, cur_xlat, cur_rel;

    logic [3:0] d_code;
    logic [1:0] d_state;
    logic       d_upd, d_push, d_irq, d_xlat, d_clr;

    logic             head_rel;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_push;

    // Stage 1: capture an accepted request and pre-check its length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_op    <= 1'b0;
            s1_short <= 1'b0;
            s1_fid   <= '0;
        end else begin
            s1_v <= req_valid && !s1_v && !s2_v;
            if (req_valid && !s1_v && !s2_v) begin
                s1_op    <= req_op;
                s1_fid   <= req_fid;
                s1_short <= (req_len < LEN_W'(MIN_LEN));
            end
        end
    end

    cfg_fid_match #(.NSLOTS(NSLOTS), .FID_W(FID_W), .IDX_W(IDX_W)) match_i (
        .occ  (occ_vec),
        .fids (fid_vec),
        .key  (s1_fid),
        .hit  (m_hit),
        .idx  (m_idx)
    );

    // Stage 2: hold the search result for the decision cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v     <= 1'b0;
            s2_op    <= 1'b0;
            s2_short <= 1'b0;
            s2_hit   <= 1'b0;
            s2_idx   <= '0;
            s2_fid   <= '0;
        end else begin
            s2_v <= s1_v;
            if (s1_v) begin
                s2_op    <= s1_op;
                s2_short <= s1_short;
                s2_hit   <= m_hit;
                s2_idx   <= m_idx;
                s2_fid   <= s1_fid;
            end
        end
    end

    cfg_slot_table #(.NSLOTS(NSLOTS), .FID_W(FID_W), .IDX_W(IDX_W)) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (slot_we),
        .set_idx   (slot_idx),
        .set_occ   (slot_occ),
        .set_fid   (slot_fid),
        .set_state (slot_state),
        .set_sum   (slot_sum),
        .set_xlat  (slot_xlat),
        .set_rel   (slot_rel),
        .upd_we    (d_upd),
        .upd_idx   (s2_idx),
        .upd_state (d_state),
        .upd_clr   (d_clr),
        .rd_idx    (s2_idx),
        .occ_vec   (occ_vec),
        .fid_vec   (fid_vec),
        .rd_state  (cur_st),
        .rd_sum    (cur_sum),
        .rd_xlat   (cur_xlat),
        .rd_rel    (cur_rel)
    );

    // Decision: response code and side effects from length, hit and state.
    always_comb begin
        d_code  = RC_NOTHING;
        d_state = cur_st;
        d_upd   = 1'b0;
        d_irq   = 1'b0;
        d_xlat  = 1'b0;
        d_clr   = 1'b0;
        if (s2_short) begin
            d_code = RC_SHORT;
        end else if (!s2_hit) begin
            d_code = RC_UNKNOWN;
        end else if (cur_st == SL_RESERVED) begin
            d_code = RC_RSVD;
        end else if (!s2_op) begin
            if (cur_st == SL_STANDBY) begin
                d_code  = RC_DONE;
                d_state = SL_DISABLED;
                d_upd   = 1'b1;
            end
        end else if (cur_st != SL_STANDBY) begin
            d_code  = RC_DONE;
            d_state = SL_STANDBY;
            d_upd   = 1'b1;
            d_clr   = 1'b1;
            d_irq   = cur_sum;
            d_xlat  = cur_xlat;
        end
        d_upd  = d_upd && s2_v;
        d_clr  = d_clr && s2_v;
        d_push = d_upd;
    end

    // Registered response and clean-up strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= '0;
            dereg_irq  <= 1'b0;
            dereg_xlat <= 1'b0;
            dereg_slot <= '0;
        end else begin
            resp_valid <= s2_v;
            dereg_irq  <= s2_v && d_irq;
            dereg_xlat <= s2_v && d_xlat;
            if (s2_v) begin
                resp_code  <= d_code;
                dereg_slot <= s2_idx;
            end
        end
    end

    cfg_event_fifo #(.DEPTH(FIFO_DEPTH), .FID_W(FID_W)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .av_push   (d_push),
        .av_fid    (s2_fid),
        .av_rel    (d_clr && cur_rel),
        .er_push   (err_push),
        .er_fid    (err_fid),
        .pop       (ev_pop),
        .pending   (ev_pending),
        .head_kind (ev_kind),
        .head_fid  (ev_fid),
        .head_rel  (head_rel),
        .count     (fifo_count),
        .push_acc  (fifo_push),
        .lost      (ev_lost)
    );

    // Unplug request accompanies the pop of a marked event.
    assign unplug_req = ev_pop && ev_pending && head_rel;
endmodule

// File: rtl/cfg_state_ctrl_chk.sv
// Property checker for cfg_state_ctrl, attached by bind below.
// Assumes: observes ports plus the queue count and accept strobe.
module cfg_state_ctrl_chk
    import cfg_state_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int FIFO_DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             resp_valid,
    input logic [3:0]       resp_code,
    input logic             dereg_irq,
    input logic             dereg_xlat,
    input logic             ev_pop,
    input logic             ev_lost,
    input logic             unplug_req,
    input logic [CNT_W-1:0] fifo_count,
    input logic             fifo_push
);
    assert_resp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_dereg_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dereg_irq || dereg_xlat) |-> (resp_valid && resp_code == RC_DONE));

    assert_short_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == RC_SHORT) |-> (!dereg_irq && !dereg_xlat));

    assert_lost_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lost |=> ev_lost);

    assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(FIFO_DEPTH));

    assert_pop_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pop && fifo_count != '0 && !fifo_push)
        |=> (fifo_count == $past(fifo_count) - 1'b1));

    assert_unplug_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unplug_req |-> (ev_pop && fifo_count != '0));
endmodule

bind cfg_state_ctrl cfg_state_ctrl_chk #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .dereg_irq  (dereg_irq),
    .dereg_xlat (dereg_xlat),
    .ev_pop     (ev_pop),
    .ev_lost    (ev_lost),
    .unplug_req (unplug_req),
    .fifo_count (fifo_count),
    .fifo_push  (fifo_push)
);

// File: tb/cfg_state_ctrl_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module cfg_state_ctrl_tb_top;
    localparam int NSLOTS = 32;
    localparam int FID_W  = 8;
    localparam int LEN_W  = 16;
    localparam int DEPTH  = 4;
    localparam int IDX_W  = $clog2(NSLOTS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             slot_we = 1'b0;
    logic [IDX_W-1:0] slot_idx = '0;
    logic             slot_occ = 1'b0;
    logic [FID_W-1:0] slot_fid = '0;
    logic [1:0]       slot_state = '0;
    logic             slot_sum = 1'b0, slot_xlat = 1'b0, slot_rel = 1'b0;
    logic             req_valid = 1'b0, req_op = 1'b0;
    logic [FID_W-1:0] req_fid = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             resp_valid;
    logic [3:0]       resp_code;
    logic             dereg_irq, dereg_xlat;
    logic [IDX_W-1:0] dereg_slot;
    logic             err_push = 1'b0;
    logic [FID_W-1:0] err_fid = '0;
    logic             ev_pop = 1'b0;
    logic             ev_pending;
    logic [1:0]       ev_kind;
    logic [FID_W-1:0] ev_fid;
    logic             unplug_req, ev_lost;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    cfg_state_ctrl #(.NSLOTS(NSLOTS), .FID_W(FID_W), .LEN_W(LEN_W), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .slot_we(slot_we), .slot_idx(slot_idx), .slot_occ(slot_occ), .slot_fid(slot_fid),
        .slot_state(slot_state), .slot_sum(slot_sum), .slot_xlat(slot_xlat), .slot_rel(slot_rel),
        .req_valid(req_valid), .req_op(req_op), .req_fid(req_fid), .req_len(req_len),
        .resp_valid(resp_valid), .resp_code(resp_code), .dereg_irq(dereg_irq),
        .dereg_xlat(dereg_xlat), .dereg_slot(dereg_slot),
        .err_push(err_push), .err_fid(err_fid), .ev_pop(ev_pop),
        .ev_pending(ev_pending), .ev_kind(ev_kind), .ev_fid(ev_fid),
        .unplug_req(unplug_req), .ev_lost(ev_lost)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FIL%s %s actual=%0h expected=%0h", "", req, act, exp);
        end
    endtask

    task automatic expect_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_slot(input int idx, input int fid, input int st,
                              input bit sum, input bit xl, input bit rel);
        slot_we = 1'b1; slot_idx = IDX_W'(idx); slot_occ = 1'b1;
        slot_fid = FID_W'(fid); slot_state = 2'(st);
        slot_sum = sum; slot_xlat = xl; slot_rel = rel;
        @(negedge clk);
        slot_we = 1'b0;
    endtask

    // Issue one request; sample the response two edges after acceptance.
    task automatic do_req(input bit op, input int fid, input int len, input bit inj_err,
                          output int code, output bit irq, output bit xl, output int slot);
        req_valid = 1'b1; req_op = op; req_fid = FID_W'(fid); req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        if (inj_err) begin err_push = 1'b1; err_fid = 8'hEE; end
        @(negedge clk);
        err_push = 1'b0;
        expect_eq("R7 resp_valid at expected cycle", int'(resp_valid), 1);
        code = int'(resp_code); irq = dereg_irq; xl = dereg_xlat; slot = int'(dereg_slot);
        @(negedge clk);
        expect_eq("R7 resp_valid single cycle", int'(resp_valid), 0);
    endtask

    task automatic req_code(input string tag, input bit op, input int fid, input int len, input int exp);
        int c; bit i; bit x; int s;
        do_req(op, fid, len, 1'b0, c, i, x, s);
        expect_eq(tag, c, exp);
    endtask

    task automatic pop_expect(input string tag, input int kind, input int fid, input bit unp);
        expect_eq({tag, " pending"}, int'(ev_pending), 1);
        expect_eq({tag, " kind"}, int'(ev_kind), kind);
        expect_eq({tag, " fid"}, int'(ev_fid), fid);
        ev_pop = 1'b1;
        #1;
        expect_eq({tag, " unplug"}, int'(unplug_req), int'(unp));
        @(negedge clk);
        ev_pop = 1'b0;
    endtask

    task automatic t_reset_state();
        expect_eq("R1 resp_valid after reset", int'(resp_valid), 0);
        expect_eq("R1 ev_pending after reset", int'(ev_pending), 0);
        expect_eq("R1 ev_lost after reset", int'(ev_lost), 0);
        req_code("R1 all slots empty", 1'b0, 8'h11, 16, 4);
        req_code("R3 unknown identifier", 1'b1, 8'h99, 40, 4);
        expect_eq("R3 no event for unknown", int'(ev_pending), 0);
    endtask

    task automatic t_setup();
        write_slot(3, 8'h21, 1, 1'b1, 1'b0, 1'b1);
        write_slot(5, 8'h30, 1, 1'b0, 1'b0, 1'b0);
        write_slot(9, 8'h30, 0, 1'b0, 1'b0, 1'b0);
        write_slot(0, 8'h40, 0, 1'b0, 1'b0, 1'b0);
        write_slot(31, 8'h50, 3, 1'b1, 1'b1, 1'b0);
        write_slot(7, 8'h60, 1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_short();
        req_code("R2 length 15 rejected", 1'b0, 8'h21, 15, 5);
        req_code("R2 short beats unknown", 1'b1, 8'h77, 0, 5);
        expect_eq("R2 no event on short", int'(ev_pending), 0);
    endtask

    task automatic t_configure();
        req_code("R4 standby to disabled", 1'b0, 8'h21, 16, 1);
        pop_expect("R8 availability event", 2, 8'h21, 1'b0);
        req_code("R4 configure disabled is no-op", 1'b0, 8'h21, 16, 2);
        req_code("R4 configure reserved", 1'b0, 8'h40, 16, 3);
        req_code("R4 configure enabled is no-op", 1'b0, 8'h50, 16, 2);
        req_code("R7 lowest index match wins", 1'b0, 8'h30, 16, 1);
        pop_expect("R7 event from slot 5", 2, 8'h30, 1'b0);
    endtask

    task automatic t_deconfigure();
        int c; bit i; bit x; int s;
        req_code("R5 deconfigure reserved", 1'b1, 8'h40, 16, 3);
        req_code("R5 deconfigure standby", 1'b1, 8'h60, 16, 2);
        do_req(1'b1, 8'h21, 16, 1'b0, c, i, x, s);
        expect_eq("R5 deconfigure disabled", c, 1);
        expect_eq("R6 irq strobe", int'(i), 1);
        expect_eq("R6 xlat strobe absent", int'(x), 0);
        expect_eq("R6 strobe slot", s, 3);
        req_code("R5 slot back in standby", 1'b1, 8'h21, 16, 2);
        pop_expect("R9 release marked pop", 2, 8'h21, 1'b1);
        do_req(1'b1, 8'h50, 16, 1'b0, c, i, x, s);
        expect_eq("R5 deconfigure enabled", c, 1);
        expect_eq("R6 irq strobe top slot", int'(i), 1);
        expect_eq("R6 xlat strobe top slot", int'(x), 1);
        expect_eq("R6 strobe slot 31", s, 31);
        pop_expect("R9 unmarked pop", 2, 8'h50, 1'b0);
    endtask

    task automatic t_setup_write();
        write_slot(12, 8'h82, 3, 1'b0, 1'b0, 1'b0);
        req_code("R12 new slot enabled", 1'b0, 8'h82, 16, 2);
        write_slot(12, 8'h82, 1, 1'b0, 1'b0, 1'b0);
        req_code("R12 rewritten to standby", 1'b0, 8'h82, 16, 1);
        pop_expect("R12 event after rewrite", 2, 8'h82, 1'b0);
    endtask

    task automatic t_busy();
        req_valid = 1'b1; req_op = 1'b0; req_fid = 8'h60; req_len = 16'd20;
        @(negedge clk);
        req_op = 1'b1; req_fid = 8'h30;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        expect_eq("R11 first response", int'(resp_valid), 1);
        expect_eq("R11 first code", int'(resp_code), 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            expect_eq("R11 no response for ignored request", int'(resp_valid), 0);
        end
        pop_expect("R11 only one event", 2, 8'h60, 1'b0);
        expect_eq("R11 queue empty", int'(ev_pending), 0);
        req_code("R11 slot 5 untouched", 1'b0, 8'h30, 16, 2);
    endtask

    task automatic t_overflow();
        for (int k = 0; k < DEPTH + 1; k++) begin
            err_push = 1'b1; err_fid = FID_W'(8'hA1 + k);
            @(negedge clk);
        end
        err_push = 1'b0;
        expect_eq("R10 lost set on full push", int'(ev_lost), 1);
        for (int k = 0; k < DEPTH; k++) begin
            pop_expect("R8 error order", 1, 8'hA1 + k, 1'b0);
        end
        expect_eq("R10 fifth push dropped", int'(ev_pending), 0);
        expect_eq("R10 lost stays set", int'(ev_lost), 1);
    endtask

    task automatic t_collision();
        int c; bit i; bit x; int s;
        do_reset();
        expect_eq("R1 lost cleared by reset", int'(ev_lost), 0);
        write_slot(2, 8'h70, 2, 1'b0, 1'b0, 1'b0);
        do_req(1'b1, 8'h70, 16, 1'b1, c, i, x, s);
        expect_eq("R10 collision response", c, 1);
        expect_eq("R6 no strobes without flags", int'(i) + int'(x), 0);
        expect_eq("R10 collision sets lost", int'(ev_lost), 1);
        pop_expect("R10 availability kept", 2, 8'h70, 1'b0);
        expect_eq("R10 error dropped", int'(ev_pending), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        t_reset_state();
        t_setup();
        t_short();
        t_configure();
        t_deconfigure();
        t_setup_write();
        t_busy();
        t_overflow();
        t_collision();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule